// File: doc/BRIEF.md
# Bit-Serial Signed Multiply-Add Unit

This unit computes a signed fixed-point product, a fused product plus addend, or a plain sum, using one full-adder cell per bit slice rather than a parallel adder tree. The multiplicand is loaded in parallel into a register that stays fixed for the whole operation. The multiplier is shifted out one bit per clock, least significant bit first, and it is sign extended across the upper half of the result width. A row of carry-save cells turns those bits into a serial product stream. A one-bit serial adder stage can follow this row to add a 2N-bit addend. The addend also enters one bit per clock.

Shift registers sit on both sides of the core. They load the operands from a parallel request and collect the serial result into a parallel word, so the user sees only a start pulse, the operand words, a busy flag, a one-cycle done pulse and a held result register. The register-to-register path inside the core is one AND gate and one full adder. The clock can therefore run fast, and the unit pays for this with roughly 2N cycles per operation.

Top module: `serial_mac`

## Requirements
- R1: While reset is asserted, and until the first accepted start, busy and done are 0 and result is all zeros.
- R2: With mode 2'b00, result equals the signed two's complement product of the multiplicand and the multiplier, as a 2N-bit word.
- R3: A multiply started by start sampled high at clock edge k raises done after edge k+2N+1 (edge k+33 for N = 16).
- R4: With mode 2'b01, result equals the signed product plus the 2N-bit addend, modulo 2^(2N).
- R5: Fused and add-only operations raise done after edge k+2N+2 (edge k+34 for N = 16), one cycle later than a multiply.
- R6: With mode[1] = 1 (2'b10 or 2'b11), result equals the addend plus the sign-extended multiplier, modulo 2^(2N). The multiplicand has no effect in this mode.
- R7: busy goes high on the edge that accepts start, stays high until the finishing edge, and falls on the same edge that raises done.
- R8: done is high for exactly one cycle, and result keeps its value between done pulses.
- R9: A start or any change of the operands or the mode while busy is high is ignored. The running operation finishes with the operands captured at its own start, at its normal cycle, and no second operation follows it.
- R10: Corner operands wrap modulo 2^(2N): (-2^(N-1)) times (-2^(N-1)) gives 2^(2N-2), and any carry out of the top bit is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an operation; sampled only while idle |
| mode | input | 2 | 00 multiply, 01 multiply-add, 1x add-only |
| mcand | input | N | Multiplicand, held in parallel |
| mplier | input | N | Multiplier, consumed serially |
| addend | input | 2N | Addend for the fused and add-only modes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 2N | Parallel result register |

## Verification
Every result falls on a fixed cycle counted from the edge that samples start. A multiply ends 2N+1 edges later, and a fused or add-only operation ends 2N+2 edges later, because a registered bit feeds the serial adder. The bench changes inputs on falling edges and counts rising edges from the start edge. At each falling edge it checks that busy is high and done is low until the expected count, then checks done, busy and the result exactly at that count. A few idle cycles afterwards confirm that the result holds and that no second operation starts.

// File: rtl/serial_mac.sv
module serial_mac #(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mode,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  input  logic [2*N-1:0] addend,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] result
);
  localparam int W  = 2 * N;
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] LAST_MUL = CW'(W);
  localparam logic [CW-1:0] LAST_ADD = CW'(W + 1);

  logic [W-1:0]  a_q, b_sh, c_sh, s_q, cy_q, r_sh, res_q, s_d, cy_d;
  logic [CW-1:0] cnt;
  logic          busy_q, done_q, add_only, use_adder, p_q, ac_q;
  logic          b_bit, sum_bit, ac_d, last;

  assign b_bit = b_sh[0];

  for (genvar j = 0; j < W; j++) begin : g_cell
    logic pp, s_in;
    assign pp = a_q[j] & b_bit;
    if (j == W - 1) begin : g_top
      assign s_in = 1'b0;
    end else begin : g_mid
      assign s_in = s_q[j+1];
    end
    assign s_d[j]  = pp ^ s_in ^ cy_q[j];
    assign cy_d[j] = (pp & s_in) | (pp & cy_q[j]) | (s_in & cy_q[j]);
  end

  assign sum_bit = p_q ^ c_sh[0] ^ ac_q;
  assign ac_d    = (p_q & c_sh[0]) | (p_q & ac_q) | (c_sh[0] & ac_q);
  assign last    = use_adder ? (cnt == LAST_ADD) : (cnt == LAST_MUL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_sh <= '0; c_sh <= '0; s_q <= '0; cy_q <= '0;
      r_sh <= '0; res_q <= '0; cnt <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; add_only <= 1'b0; use_adder <= 1'b0;
      p_q <= 1'b0; ac_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q    <= 1'b1;
          cnt       <= '0;
          a_q       <= {{N{mcand[N-1]}}, mcand};
          b_sh      <= {{N{mplier[N-1]}}, mplier};
          c_sh      <= addend;
          s_q       <= '0;
          cy_q      <= '0;
          p_q       <= 1'b0;
          ac_q      <= 1'b0;
          add_only  <= mode[1];
          use_adder <= mode[1] | mode[0];
        end
      end else begin
        cnt  <= cnt + 1'b1;
        s_q  <= s_d;
        cy_q <= cy_d;
        b_sh <= {b_sh[W-1], b_sh[W-1:1]};
        p_q  <= add_only ? b_bit : s_d[0];
        if (!use_adder) begin
          if (cnt < LAST_MUL) r_sh <= {s_d[0], r_sh[W-1:1]};
        end else if (cnt != '0 && cnt <= LAST_MUL) begin
          r_sh <= {sum_bit, r_sh[W-1:1]};
          ac_q <= ac_d;
          c_sh <= {1'b0, c_sh[W-1:1]};
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= r_sh;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/serial_mac_chk.sv
module serial_mac_chk #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [1:0]     mode,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] result
);
  localparam int W  = 2 * N;
  localparam int LW = $clog2(W + 4);
  logic [LW-1:0] lat;
  logic          adder_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat <= '0;
      adder_op <= 1'b0;
    end else if (!busy && start) begin
      lat <= '0;
      adder_op <= |mode;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  p_mul_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !adder_op) |-> lat == LW'(W + 1));
  p_add_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && adder_op) |-> lat == LW'(W + 2));
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind serial_mac serial_mac_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
  .busy(busy), .done(done), .result(result)
);

// File: tb/sim_serial_mac.sv
`timescale 1ns/1ps
module sim_serial_mac;
  localparam int N = 16;
  localparam int W = 2 * N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic [N-1:0] mcand = '0, mplier = '0;
  logic [W-1:0] addend = '0;
  logic busy, done;
  logic [W-1:0] result;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  serial_mac #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mcand(mcand),
    .mplier(mplier), .addend(addend), .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [1:0] m, input logic [N-1:0] a,
                                         input logic [N-1:0] b, input logic [W-1:0] c);
    logic [W-1:0] sa, sb;
    sa = {{N{a[N-1]}}, a};
    sb = {{N{b[N-1]}}, b};
    if (m[1]) return c + sb;
    if (m[0]) return sa * sb + c;
    return sa * sb;
  endfunction

  task automatic run_op(input logic [1:0] m, input logic [N-1:0] a, input logic [N-1:0] b,
                        input logic [W-1:0] c, input bit intrude, input string tag);
    logic [W-1:0] exp;
    int lat, k;
    bit seq_ok;
    exp = model(m, a, b, c);
    lat = (m == 2'b00) ? W + 1 : W + 2;
    @(negedge clk);
    mode = m; mcand = a; mplier = b; addend = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    seq_ok = 1'b1;
    while (k < lat + 4) begin
      @(posedge clk);
      @(negedge clk);
      k = k + 1;
      if (intrude && k == 5) begin
        start = 1'b1; mode = ~m; mcand = ~a; mplier = b + 1'b1; addend = ~c;
      end
      if (intrude && k == 6) start = 1'b0;
      if (k < lat && (!busy || done)) seq_ok = 1'b0;
      if (k == lat) break;
    end
    // R3 / R5: done due exactly lat edges after the start edge
    chk(seq_ok && done && !busy && k == lat,
        (m == 2'b00) ? {tag, " R3 R7 latency"} : {tag, " R5 R7 latency"},
        W'(k), W'(lat));
    chk(result == exp, tag, result, exp);
    @(negedge clk);
    chk(!done && result == exp, {tag, " R8 pulse and hold"}, result, exp);
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk(!busy && !done, {tag, " R9 no second operation"}, W'({busy, done}), '0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == '0, "R1 reset state", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && result == '0, "R1 idle after reset", result, '0);

    run_op(2'b00, 16'd3, 16'd5, '0, 1'b0, "R2 mul small");
    run_op(2'b00, 16'hFFF9, 16'd9, '0, 1'b0, "R2 mul neg*pos");
    run_op(2'b00, 16'hFFFF, 16'hFFFF, '0, 1'b0, "R2 mul neg*neg");
    run_op(2'b00, 16'h7FFF, 16'h8000, 32'hDEAD_BEEF, 1'b0, "R2 mul max*min addend ignored");
    run_op(2'b00, 16'h8000, 16'h8000, '0, 1'b0, "R10 mul min*min");
    run_op(2'b01, 16'd100, 16'd200, 32'd5, 1'b0, "R4 fused basic");
    run_op(2'b01, 16'hFFFD, 16'd4, 32'hFFFF_FFF0, 1'b0, "R4 fused negative");
    run_op(2'b01, 16'h8000, 16'h8000, 32'hC000_0000, 1'b0, "R10 fused wrap to zero");
    run_op(2'b10, 16'h1234, 16'hFFFD, 32'd10, 1'b0, "R6 add mcand ignored");
    run_op(2'b11, 16'hFFFF, 16'h7FFF, 32'hFFFF_0001, 1'b0, "R6 add mode 11");
    run_op(2'b10, 16'h0000, 16'h0001, 32'hFFFF_FFFF, 1'b0, "R10 add carry out dropped");
    run_op(2'b01, 16'h0123, 16'hFF00, 32'h0000_1111, 1'b1, "R9 fused start while busy");
    run_op(2'b00, 16'h0BCD, 16'h0321, '0, 1'b1, "R9 mul start while busy");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule